// File: doc/BRIEF.md
# Burst Line-Fill Read Master

This block is the read-side bus master that sits between a cache controller and a fast on-chip memory on a Wishbone-style bus. The cache side presents a request with a byte address and a flag that selects either a full line fill or a single word. The block then drives the cycle, strobe and address lines and watches acknowledge. Each acknowledged word goes back to the cache with a valid strobe, the data, and the position of the word inside its line.

The design targets memory that can acknowledge in the same cycle it is strobed. A line is four 32-bit words. The strobe stays high across the whole burst, so a fill delivers one word per clock. A request cycle plus four bus cycles gives five clocks for a line. A single-word read takes two clocks.

The request handshake is open during the cycle that carries the final acknowledge. A follow-on request presented there keeps the cycle line high with no idle gap between transfers.

Top module: `burst_fill_master`

## Requirements
- R1: After reset, bus_cyc, bus_stb, rsp_valid and rsp_done are 0 and req_ready is 1.
- R2: A request accepted while idle (req_valid and req_ready high at a rising edge) drives bus_cyc and bus_stb high from the next cycle onward.
- R3: For a line fill (req_line=1), the first bus address is the request address with its low four byte-address bits cleared. Each acknowledged beat advances the address by 4 bytes, so the words come in ascending order.
- R4: With acknowledge high every cycle, a line fill keeps bus_cyc and bus_stb high for exactly four consecutive cycles. rsp_done is high in the fifth clock counted from the request cycle.
- R5: A single-word read (req_line=0) puts the request address with its low two bits cleared on the bus for one beat. It completes with rsp_done in the second clock counted from the request cycle.
- R6: While bus_ack is low during a transfer, bus_adr stays stable, bus_stb stays high, rsp_valid stays low, and the beat is not counted.
- R7: rsp_valid is high exactly in cycles where bus_stb and bus_ack are both high. rsp_data then equals bus_dat_i, and rsp_idx equals byte-address bits [3:2] of the word on the bus (0..3).
- R8: rsp_done is high only in the cycle of the final acknowledged beat (the fourth for a line, the only one for a single read). If no new request is accepted in that cycle, bus_cyc and bus_stb are low in the next cycle.
- R9: req_ready is high when idle and in the final-beat cycle. A request accepted in the final-beat cycle keeps bus_cyc high without a gap and places its own first address on the bus in the next cycle.
- R10: During a transfer, outside the final-beat cycle, req_ready is low. A request presented then is ignored: it does not change the address sequence and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Cache side presents a request |
| req_line | input | 1 | 1 = four-word line fill, 0 = single word |
| req_addr | input | AW (32) | Byte address of the request |
| req_ready | output | 1 | Request is accepted at this edge if req_valid is high |
| rsp_valid | output | 1 | A word is returned in this cycle |
| rsp_data | output | DW (32) | Returned word |
| rsp_idx | output | log2(WORDS) (2) | Index of the returned word within its line |
| rsp_done | output | 1 | Final word of the transfer is returned in this cycle |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Bus strobe |
| bus_adr | output | AW (32) | Bus byte address |
| bus_ack | input | 1 | Memory acknowledge |
| bus_dat_i | input | DW (32) | Read data from memory |

## Verification
The assertions check the following on every cycle:
- the line-aligned first address;
- the four-byte step on each acknowledged beat;
- the frozen address and beat count during a stall;
- the cycle line dropping, or staying high, after the final beat depending on whether a follow-on request was taken;
- the last index of a line matching the done pulse.

Only the bench scenarios can show the end-to-end clock counts of a fill and a single read. The same holds for a rejected mid-burst request leaving no trace on the bus, and for the returned data pairing with the right address.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } bfm_state_e;

    typedef struct packed {
        bfm_state_e state;
        logic       line;
    } bfm_ctrl_t;

endpackage

// File: rtl/bfm_ctrl.sv
module bfm_ctrl
    import bfm_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int IDXW = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_line,
    input  logic            bus_ack,
    input  logic [IDXW-1:0] beat_q,
    output logic            busy,
    output logic            line_mode,
    output logic            accept,
    output logic            fin,
    output logic            req_ready
);

    localparam logic [IDXW-1:0] LAST_BEAT = IDXW'(WORDS - 1);

    bfm_ctrl_t ctl_d, ctl_q;
    logic      last_beat;

    always_comb begin
        busy      = (ctl_q.state == ST_BUSY);
        line_mode = ctl_q.line;
        last_beat = !ctl_q.line || (beat_q == LAST_BEAT);
        fin       = busy && bus_ack && last_beat;
        req_ready = !busy || fin;
        accept    = req_valid && req_ready;

        ctl_d = ctl_q;
        if (accept) begin
            ctl_d.state = ST_BUSY;
            ctl_d.line  = req_line;
        end else if (fin) begin
            ctl_d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.line  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        fin && !req_valid |=> !busy); // R8
    AST_CHAIN_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        fin && req_valid |=> busy); // R9
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !fin |=> busy && $stable(line_mode)); // R10

endmodule

// File: rtl/bfm_addr_gen.sv
module bfm_addr_gen #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WORDS = 4,
    localparam int IDXW     = $clog2(WORDS),
    localparam int WOFF     = $clog2(DW / 8),
    localparam int LINE_OFF = $clog2(WORDS * DW / 8)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            req_line,
    input  logic [AW-1:0]   req_addr,
    input  logic            busy,
    input  logic            bus_ack,
    output logic [AW-1:0]   adr_q,
    output logic [IDXW-1:0] beat_q
);

    localparam logic [AW-1:0] STEP      = AW'(DW / 8);
    localparam logic [AW-1:0] WORD_MASK = AW'((1 << WOFF) - 1);
    localparam logic [AW-1:0] LINE_MASK = AW'((1 << LINE_OFF) - 1);

    typedef struct packed {
        logic [AW-1:0]   adr;
        logic [IDXW-1:0] beat;
    } agen_t;

    agen_t ag_d, ag_q;

    always_comb begin
        ag_d = ag_q;
        if (accept) begin
            ag_d.adr  = req_line ? (req_addr & ~LINE_MASK) : (req_addr & ~WORD_MASK);
            ag_d.beat = '0;
        end else if (busy && bus_ack) begin
            ag_d.adr  = ag_q.adr + STEP;
            ag_d.beat = ag_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ag_q <= '0;
        end else begin
            ag_q <= ag_d;
        end
    end

    assign adr_q  = ag_q.adr;
    assign beat_q = ag_q.beat;

    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_line |=> adr_q[LINE_OFF-1:0] == '0 && beat_q == '0); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && bus_ack && !accept |=> adr_q == $past(adr_q) + STEP); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bus_ack |=> $stable(adr_q) && $stable(beat_q)); // R6

endmodule

// File: rtl/bfm_resp.sv
module bfm_resp #(
    parameter int DW    = 32,
    parameter int WORDS = 4,
    localparam int IDXW = $clog2(WORDS)
) (
    input  logic            busy,
    input  logic            bus_ack,
    input  logic            fin,
    input  logic [DW-1:0]   bus_dat_i,
    input  logic [IDXW-1:0] adr_idx,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic [IDXW-1:0] rsp_idx,
    output logic            rsp_done
);

    always_comb begin
        rsp_valid = busy && bus_ack;
        rsp_data  = rsp_valid ? bus_dat_i : '0;
        rsp_idx   = adr_idx;
        rsp_done  = fin;
    end

    always_comb begin
        assert (!rsp_done || rsp_valid); // R8
    end

endmodule

// File: rtl/burst_fill_master.sv
module burst_fill_master #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WORDS = 4,
    localparam int IDXW     = $clog2(WORDS),
    localparam int WOFF     = $clog2(DW / 8),
    localparam int LINE_OFF = $clog2(WORDS * DW / 8)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_line,
    input  logic [AW-1:0]   req_addr,
    output logic            req_ready,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic [IDXW-1:0] rsp_idx,
    output logic            rsp_done,
    output logic            bus_cyc,
    output logic            bus_stb,
    output logic [AW-1:0]   bus_adr,
    input  logic            bus_ack,
    input  logic [DW-1:0]   bus_dat_i
);

    logic            busy;
    logic            line_mode;
    logic            accept;
    logic            fin;
    logic [AW-1:0]   adr_q;
    logic [IDXW-1:0] beat_q;

    bfm_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_line  (req_line),
        .bus_ack   (bus_ack),
        .beat_q    (beat_q),
        .busy      (busy),
        .line_mode (line_mode),
        .accept    (accept),
        .fin       (fin),
        .req_ready (req_ready)
    );

    bfm_addr_gen #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_agen (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_line (req_line),
        .req_addr (req_addr),
        .busy     (busy),
        .bus_ack  (bus_ack),
        .adr_q    (adr_q),
        .beat_q   (beat_q)
    );

    bfm_resp #(.DW(DW), .WORDS(WORDS)) u_resp (
        .busy      (busy),
        .bus_ack   (bus_ack),
        .fin       (fin),
        .bus_dat_i (bus_dat_i),
        .adr_idx   (adr_q[LINE_OFF-1:WOFF]),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_idx   (rsp_idx),
        .rsp_done  (rsp_done)
    );

    assign bus_cyc = busy;
    assign bus_stb = busy;
    assign bus_adr = adr_q;

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cyc |-> !rsp_valid && req_ready); // R1
    AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cyc && req_valid |=> bus_cyc && bus_stb); // R2
    AST_LINE_LAST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done && line_mode |-> rsp_idx == IDXW'(WORDS - 1)); // R4

endmodule

// File: tb/tb_burst_fill_master.sv
`timescale 1ns/100ps
module tb_burst_fill_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_line = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [1:0]  rsp_idx;
    logic        rsp_done;
    logic        bus_cyc;
    logic        bus_stb;
    logic [31:0] bus_adr;
    logic        bus_ack;
    logic [31:0] bus_dat_i;
    logic        ack_en = 1'b1;

    int n_checks = 0;
    int n_errs   = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    assign bus_ack   = bus_stb & ack_en;
    assign bus_dat_i = bus_stb ? mem_word(bus_adr) : 32'h0;

    burst_fill_master dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
        .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_idx(rsp_idx), .rsp_done(rsp_done),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_adr(bus_adr),
        .bus_ack(bus_ack), .bus_dat_i(bus_dat_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        #1;
        chk(bus_cyc == 0 && bus_stb == 0, "R1 bus idle", {30'b0, bus_cyc, bus_stb}, 0);
        chk(rsp_valid == 0 && rsp_done == 0, "R1 rsp idle", {30'b0, rsp_valid, rsp_done}, 0);
        chk(req_ready == 1, "R1 ready", {31'b0, req_ready}, 1);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_line(input logic [31:0] addr);
        logic [31:0] base;
        int clocks;
        base = addr & ~32'hF;
        @(negedge clk);
        req_valid = 1; req_line = 1; req_addr = addr; ack_en = 1;
        #1 chk(req_ready == 1, "R9 ready when idle", {31'b0, req_ready}, 1);
        chk(bus_cyc == 0, "R2 no cycle before accept", {31'b0, bus_cyc}, 0);
        clocks = 1;
        @(negedge clk); req_valid = 0;
        for (int i = 0; i < 4; i++) begin
            clocks++;
            #1;
            chk(bus_cyc && bus_stb, "R4 strobe held across burst", {30'b0, bus_cyc, bus_stb}, 3);
            if (i == 0) chk(bus_cyc, "R2 cycle starts next clock", {31'b0, bus_cyc}, 1);
            chk(bus_adr == base + 32'(4 * i), "R3 ascending address", bus_adr, base + 32'(4 * i));
            chk(rsp_valid == 1, "R7 valid on ack", {31'b0, rsp_valid}, 1);
            chk(rsp_idx == 2'(i), "R7 word index", {30'b0, rsp_idx}, i);
            chk(rsp_data == mem_word(base + 32'(4 * i)), "R7 data", rsp_data, mem_word(base + 32'(4 * i)));
            chk(rsp_done == (i == 3), "R8 done only on last", {31'b0, rsp_done}, {31'b0, i == 3});
            if (i < 3) @(negedge clk);
        end
        chk(clocks == 5, "R4 five clocks per line", clocks, 5);
        @(negedge clk); #1;
        chk(bus_cyc == 0 && bus_stb == 0, "R8 drop after last", {30'b0, bus_cyc, bus_stb}, 0);
        chk(rsp_valid == 0, "R8 no valid after last", {31'b0, rsp_valid}, 0);
    endtask

    task automatic t_single(input logic [31:0] addr);
        logic [31:0] wa;
        wa = addr & ~32'h3;
        @(negedge clk);
        req_valid = 1; req_line = 0; req_addr = addr; ack_en = 1;
        @(negedge clk); req_valid = 0; #1;
        chk(bus_cyc == 1, "R5 single on bus in clock 2", {31'b0, bus_cyc}, 1);
        chk(bus_adr == wa, "R5 word aligned", bus_adr, wa);
        chk(rsp_done == 1 && rsp_valid == 1, "R5 done in clock 2", {30'b0, rsp_done, rsp_valid}, 3);
        chk(rsp_idx == wa[3:2], "R7 single index", {30'b0, rsp_idx}, {30'b0, wa[3:2]});
        chk(rsp_data == mem_word(wa), "R7 single data", rsp_data, mem_word(wa));
        @(negedge clk); #1;
        chk(bus_cyc == 0, "R8 single drops", {31'b0, bus_cyc}, 0);
    endtask

    task automatic t_stall(input logic [31:0] base);
        @(negedge clk);
        req_valid = 1; req_line = 1; req_addr = base; ack_en = 1;
        @(negedge clk); req_valid = 0; #1;
        chk(rsp_valid && rsp_idx == 0, "R7 stall case beat0", {30'b0, rsp_idx}, 0);
        @(negedge clk);
        ack_en = 0; req_valid = 1; req_line = 0; req_addr = 32'h0000_0F04; #1;
        chk(req_ready == 0, "R10 not ready mid burst", {31'b0, req_ready}, 0);
        chk(rsp_valid == 0, "R6 no valid while stalled", {31'b0, rsp_valid}, 0);
        chk(bus_stb == 1 && bus_adr == base + 4, "R6 strobe and addr during stall", bus_adr, base + 4);
        @(negedge clk); req_valid = 0; #1;
        chk(bus_adr == base + 4 && bus_stb, "R6 addr stable second stall", bus_adr, base + 4);
        chk(rsp_idx == 1, "R6 beat not counted", {30'b0, rsp_idx}, 1);
        @(negedge clk); ack_en = 1; #1;
        chk(rsp_valid && rsp_data == mem_word(base + 4), "R6 resume beat1", rsp_data, mem_word(base + 4));
        @(negedge clk); #1;
        chk(bus_adr == base + 8, "R10 sequence undisturbed", bus_adr, base + 8);
        @(negedge clk); #1;
        chk(rsp_done && rsp_idx == 3, "R6 done after stall", {30'b0, rsp_idx}, 3);
        @(negedge clk); #1;
        chk(bus_cyc == 0, "R10 ignored request starts nothing", {31'b0, bus_cyc}, 0);
    endtask

    task automatic t_chain(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        req_valid = 1; req_line = 1; req_addr = a; ack_en = 1;
        @(negedge clk); req_valid = 0;
        repeat (3) @(negedge clk);
        req_valid = 1; req_line = 0; req_addr = b; #1;
        chk(rsp_done && req_ready, "R9 ready in final beat", {30'b0, rsp_done, req_ready}, 3);
        @(negedge clk); req_valid = 0; #1;
        chk(bus_cyc == 1, "R9 no gap between transfers", {31'b0, bus_cyc}, 1);
        chk(bus_adr == (b & ~32'h3), "R9 chained address", bus_adr, b & ~32'h3);
        chk(rsp_done == 1, "R9 chained single done", {31'b0, rsp_done}, 1);
        @(negedge clk); #1;
        chk(bus_cyc == 0, "R8 idle after chain", {31'b0, bus_cyc}, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_line(32'h0000_1000);
        t_line(32'h1000_0028);
        t_single(32'h0000_2006);
        t_single(32'h0000_300C);
        t_stall(32'h0000_4010);
        t_chain(32'h0000_5000, 32'h0000_6008);
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule